// File: doc/BRIEF.md
# Command-Driven SPI Word Transfer Unit

This block runs a stream of 16-bit command words and turns them into SPI bus activity. A transfer command asks for a number of words, each of which is shifted out on SDO, shifted in from SDI, or both. Write data arrives on a valid/ready stream and read data leaves on another valid/ready stream. A configuration command updates one of three 8-bit settings, which take effect from the next transfer:
- the clock divider;
- the bus mode (clock polarity, clock phase, three-wire flag, SDO rest level);
- the word length in bits.

Commands the unit does not execute itself are passed unchanged to a companion timing unit. Examples are chip-select changes, sleeps and sync markers. The handshake for these commands is a straight pass-through.

The serial clock runs at the module clock divided by 2*(div+1). Words go out most significant bit first. A word may be shorter than the DATA_WIDTH parameter: only its low L bits are sent, and a read word is returned right-aligned with its upper bits zero. Execution stalls at a word boundary in two cases: a write word is not yet offered, or a finished read word is not yet taken. No serial clock edge is produced while the unit is stalled. The command stream is accepted only while the unit is idle.

Top module: `spi_cmd_xfer`

## Requirements
- R1: After reset the outputs are: sclk 0, sdo 0, sdo_t 1, three_wire 0, wr_ready 0, rd_valid 0 and side_valid 0. The registers hold: divider 0, mode 0, length DATA_WIDTH.
- R2: A command whose bits [15:10] are 001000 is a configuration write, accepted in one cycle while idle. Bits [9:8] select the register and bits [7:0] give the value: 00 is the divider, 01 is the mode, 10 is the length, and 11 changes nothing. Mode bits [7:4] are discarded.
- R3: Each serial clock half period lasts div+1 module clocks. Between transfers sclk rests at the polarity bit, which is mode bit 1.
- R4: With phase 0 (mode bit 0 clear), each SDO bit is valid before the leading edge of its clock, most significant bit first. SDI is captured on leading edges.
- R5: With phase 1, SDO changes on leading edges and SDI is captured on trailing edges.
- R6: A command with bits [15:10] equal to 000000 is a transfer. Bit 9 enables reading, bit 8 enables writing, and bits [7:0] hold the word count minus one. While a writing transfer runs, sdo_t is 0; otherwise sdo_t is 1. One write word is consumed per transfer word.
- R7: A reading transfer presents every received word on rd_data with rd_valid. rd_data stays stable until rd_ready.
- R8: While wr_ready is high with no wr_valid, or rd_valid is high with no rd_ready, sclk does not toggle.
- R9: Each word has L bits, where L is the length register. A length of 0, or one above DATA_WIDTH, means DATA_WIDTH. Only the low L bits of a write word are sent.
- R10: SDO shows the rest level (mode bit 3) when cs_act is low, during transfers that do not write, and while idle. Mode bit 2 drives three_wire.
- R11: Any other command is forwarded on side_cmd with side_valid. cmd_ready then follows side_ready, and no serial activity results.
- R12: After a transfer command is accepted, cmd_ready stays low until the last word has finished, including its read handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_data | input | 16 | Command word |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken |
| side_cmd | output | 16 | Forwarded command for the timing unit |
| side_valid | output | 1 | Forwarded command offered |
| side_ready | input | 1 | Timing unit takes the forwarded command |
| wr_data | input | DW | Outgoing word |
| wr_valid | input | 1 | Outgoing word offered |
| wr_ready | output | 1 | Outgoing word taken |
| rd_data | output | DW | Received word, right-aligned |
| rd_valid | output | 1 | Received word offered |
| rd_ready | input | 1 | Received word taken |
| cs_act | input | 1 | Chip-select active, from the timing unit |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_t | output | 1 | SDO tristate control, 1 releases the line |
| sdi | input | 1 | Serial data in |
| three_wire | output | 1 | Three-wire mode flag |

## Verification
Each result has its own due cycle:
- A configuration value is visible on sclk, sdo and three_wire one clock after the accepting edge.
- The first serial clock edge of a word comes div+1 clocks after the word starts.
- rd_valid rises one clock after the last sampling edge of a word.
- The forwarded-command handshake is combinational in the same cycle.

The bench drives and samples only on falling clock edges, half a period away from the edges where the design changes. Its bus model acts on every sclk change it sees: it takes the SDO value held just before the active edge and moves SDI on after the edge. Stall windows are judged one cycle later, against the handshake levels that were present before the rising edge.

// File: rtl/spi_cmd_xfer.sv
module spi_cmd_xfer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   cmd_data,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  output logic [15:0]   side_cmd,
  output logic          side_valid,
  input  logic          side_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  input  logic          cs_act,
  output logic          sclk,
  output logic          sdo,
  output logic          sdo_t,
  input  logic          sdi,
  output logic          three_wire
);

  localparam int LW = $clog2(DW + 1);
  localparam int CW = $clog2(2 * DW) + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_PUSH} st_t;

  st_t st_q;
  logic [7:0] div_q, len_q, cnt_q, pc_q;
  logic [3:0] mode_q;
  logic rd_en_q, wr_en_q, ph_q, sdo_q;
  logic [CW-1:0] edge_q;
  logic [DW-1:0] tx_q, rx_q;

  logic [LW-1:0] eff;
  logic [CW-1:0] last_edge;
  logic [DW-1:0] tx_al;
  logic is_xfer, is_cfg, is_side, idle, fire;
  logic tick, lead, sample_now, update_now, word_end;
  logic advance, more, start_run;
  wire cpha = mode_q[0];
  wire cpol = mode_q[1];

  assign is_xfer = cmd_data[15:10] == 6'b000000;
  assign is_cfg  = cmd_data[15:10] == 6'b001000;
  assign is_side = !is_xfer && !is_cfg;
  assign idle    = st_q == S_IDLE;

  assign cmd_ready  = idle && (is_side ? side_ready : 1'b1);
  assign side_valid = idle && cmd_valid && is_side;
  assign side_cmd   = cmd_data;
  assign fire       = cmd_valid && cmd_ready;

  always_comb begin
    if (len_q == 8'd0 || int'(len_q) > DW) eff = LW'(DW);
    else eff = LW'(len_q);
  end

  assign last_edge = CW'({1'b0, eff, 1'b0}) - CW'(1);
  assign tx_al     = wr_data << (DW - int'(eff));

  assign tick       = (st_q == S_RUN) && (pc_q == div_q);
  assign lead       = !edge_q[0];
  assign sample_now = tick && (lead ^ cpha);
  assign word_end   = tick && (edge_q == last_edge);
  assign update_now = tick && !(lead ^ cpha) && !(!cpha && edge_q == last_edge);

  assign more      = cnt_q != 8'd0;
  assign advance   = (st_q == S_RUN && word_end && !rd_en_q) || (st_q == S_PUSH && rd_ready);
  assign start_run = (idle && fire && is_xfer && !cmd_data[8])
                  || (advance && more && !wr_en_q)
                  || (st_q == S_LOAD && wr_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      case (st_q)
        S_IDLE: if (fire && is_xfer) st_q <= cmd_data[8] ? S_LOAD : S_RUN;
        S_LOAD: if (wr_valid) st_q <= S_RUN;
        S_RUN:  if (word_end) begin
                  if (rd_en_q) st_q <= S_PUSH;
                  else if (!more) st_q <= S_IDLE;
                  else st_q <= wr_en_q ? S_LOAD : S_RUN;
                end
        S_PUSH: if (rd_ready) begin
                  if (!more) st_q <= S_IDLE;
                  else st_q <= wr_en_q ? S_LOAD : S_RUN;
                end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 8'd0;
      mode_q <= 4'd0;
      len_q  <= 8'(DW);
    end else if (idle && fire && is_cfg) begin
      case (cmd_data[9:8])
        2'b00:   div_q  <= cmd_data[7:0];
        2'b01:   mode_q <= cmd_data[3:0];
        2'b10:   len_q  <= cmd_data[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
      cnt_q   <= 8'd0;
    end else if (idle && fire && is_xfer) begin
      rd_en_q <= cmd_data[9];
      wr_en_q <= cmd_data[8];
      cnt_q   <= cmd_data[7:0];
    end else if (advance && more) begin
      cnt_q <= cnt_q - 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= 8'd0;
      edge_q <= '0;
      ph_q   <= 1'b0;
    end else if (start_run) begin
      pc_q   <= 8'd0;
      edge_q <= '0;
      ph_q   <= 1'b0;
    end else if (tick) begin
      pc_q   <= 8'd0;
      edge_q <= edge_q + CW'(1);
      ph_q   <= ~ph_q;
    end else if (st_q == S_RUN) begin
      pc_q <= pc_q + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      sdo_q <= 1'b0;
    end else if (st_q == S_LOAD && wr_valid) begin
      if (!cpha) begin
        sdo_q <= tx_al[DW-1];
        tx_q  <= tx_al << 1;
      end else begin
        tx_q <= tx_al;
      end
    end else if (update_now) begin
      sdo_q <= tx_q[DW-1];
      tx_q  <= tx_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= '0;
    else if (start_run) rx_q <= '0;
    else if (sample_now) rx_q <= {rx_q[DW-2:0], sdi};
  end

  wire xfer_w = wr_en_q && !idle;

  assign sclk       = ph_q ^ cpol;
  assign sdo_t      = !xfer_w;
  assign sdo        = (xfer_w && cs_act) ? sdo_q : mode_q[3];
  assign three_wire = mode_q[2];
  assign wr_ready   = st_q == S_LOAD;
  assign rd_valid   = st_q == S_PUSH;
  assign rd_data    = rx_q;

  assert_idle_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> (sclk == mode_q[1]));

  assert_no_early_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && pc_q != div_q) |=> $stable(sclk));

  assert_wr_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> (wr_ready && $stable(sclk)));

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(sclk)));

  assert_sdo_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !sdo_t);

  assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_data[15:10] == 6'b000000) |=> !cmd_ready);

  assert_side_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    side_valid |-> !(wr_ready || rd_valid));

endmodule

// File: tb/spi_cmd_xfer_tb.sv
`timescale 1ns/1ps
module spi_cmd_xfer_tb;
  logic clk = 0, rst_n = 0;
  logic [15:0] cmd_data = 0;
  logic cmd_valid = 0, side_ready = 0;
  logic [15:0] side_cmd;
  logic cmd_ready, side_valid;
  logic [7:0] wr_data = 0;
  logic wr_valid = 0, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, rd_ready = 0;
  logic cs_act = 1, sdi = 0;
  logic sclk, sdo, sdo_t, three_wire;

  always #2.5 clk = ~clk;

  spi_cmd_xfer #(.DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .side_cmd(side_cmd), .side_valid(side_valid), .side_ready(side_ready),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .cs_act(cs_act), .sclk(sclk), .sdo(sdo), .sdo_t(sdo_t), .sdi(sdi), .three_wire(three_wire));

  int n_tests = 0, n_fail = 0;

  logic [7:0] wr_arr[8], s_tx[8], rx_words[8], rd_got[8];
  int wr_idx, wr_n, hold_at, hold_len, hold_cnt, rd_wait, rd_reload;
  int nrx, nrd, bits, s_w, s_bit, toggles, since, gap_min, gap_max;
  int bad_sdot, bad_idle, stall_bad, stall_cycles;
  bit wr_on, wr_fire, have_tog, stall_prev, tb_cpol, tb_cpha, tb_sdot_exp, tb_idle_exp, tb_idle_val;
  int tb_len = 8;
  logic sclk_prev, sdo_p, sdot_p;
  logic [7:0] rx_sh;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (wr_fire) begin
      wr_idx++;
      if (wr_idx == hold_at) hold_cnt = hold_len;
    end
    if (hold_cnt > 0) begin
      hold_cnt--;
      wr_valid = 0;
    end else begin
      wr_valid = wr_on && (wr_idx < wr_n);
    end
    wr_data = wr_arr[wr_idx & 7];
    wr_fire = wr_valid && wr_ready;

    if (rd_valid) begin
      if (rd_wait > 0) begin
        rd_wait--;
        rd_ready = 0;
      end else begin
        rd_ready = 1;
        rd_got[nrd & 7] = rd_data;
        nrd++;
        rd_wait = rd_reload;
      end
    end else rd_ready = 0;

    if (sclk !== sclk_prev) begin
      toggles++;
      if (stall_prev) stall_bad++;
      if (have_tog) begin
        if (since + 1 < gap_min) gap_min = since + 1;
        if (since + 1 > gap_max) gap_max = since + 1;
      end
      have_tog = 1;
      since = 0;
      if ((sclk_prev == tb_cpol) ^ tb_cpha) begin
        rx_sh = {rx_sh[6:0], sdo_p};
        if (sdot_p !== tb_sdot_exp) bad_sdot++;
        if (tb_idle_exp && sdo_p !== tb_idle_val) bad_idle++;
        bits++;
        if (bits == tb_len) begin
          rx_words[nrx & 7] = rx_sh & 8'((1 << tb_len) - 1);
          nrx++;
          rx_sh = 0;
          bits = 0;
        end
        s_bit++;
        if (s_bit == tb_len) begin
          s_bit = 0;
          s_w++;
        end
        sdi = s_tx[s_w & 7][tb_len - 1 - s_bit];
      end
    end else since++;
    sclk_prev = sclk;
    stall_prev = (wr_ready && !wr_valid) || (rd_valid && !rd_ready);
    if (stall_prev) stall_cycles++;
    sdo_p = sdo;
    sdot_p = sdo_t;
  end

  task automatic send(logic [15:0] c);
    @(negedge clk);
    cmd_data = c;
    cmd_valid = 1;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cmd_valid = 0;
    cmd_data = 0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic cfg(logic [1:0] r, logic [7:0] v);
    send({6'b001000, r, v});
  endtask

  task automatic prep(int len, bit cpol, bit cpha, bit sdot_exp, int nwr, int rdwait);
    tb_len = len; tb_cpol = cpol; tb_cpha = cpha; tb_sdot_exp = sdot_exp;
    wr_idx = 0; wr_n = nwr; wr_on = nwr > 0; wr_fire = 0; hold_at = -1; hold_cnt = 0;
    rd_reload = rdwait; rd_wait = rdwait;
    nrx = 0; nrd = 0; bits = 0; s_w = 0; s_bit = 0; rx_sh = 0;
    toggles = 0; since = 0; gap_min = 1000; gap_max = 0; have_tog = 0;
    bad_sdot = 0; bad_idle = 0; stall_bad = 0; stall_cycles = 0;
    tb_idle_exp = 0;
    sclk_prev = sclk;
    sdi = s_tx[0][len - 1];
  endtask

  task automatic test_reset();
    #1;
    chk(sclk == 0 && sdo == 0, "R1", "sclk/sdo after reset", {sclk, sdo}, 0);
    chk(sdo_t == 1 && three_wire == 0, "R1", "sdo_t/three_wire after reset", {sdo_t, three_wire}, 2);
    chk(!wr_ready && !rd_valid && !side_valid, "R1", "stream flags", {wr_ready, rd_valid, side_valid}, 0);
    chk(cmd_ready == 1, "R1", "cmd_ready idle", cmd_ready, 1);
  endtask

  task automatic test_mode0();
    cfg(2'b00, 8'd1); cfg(2'b01, 8'h00);
    wr_arr[0] = 8'hA5; wr_arr[1] = 8'h3C; s_tx[0] = 8'h5A; s_tx[1] = 8'hC3;
    prep(8, 0, 0, 0, 2, 3);
    send(16'h0301);
    send(16'h2001);
    chk(nrd == 2, "R12", "config held off until transfer ends", nrd, 2);
    chk(rx_words[0] == 8'hA5 && rx_words[1] == 8'h3C, "R4", "mode0 SDO words",
        {rx_words[0], rx_words[1]}, 16'hA53C);
    chk(rd_got[0] == 8'h5A && rd_got[1] == 8'hC3, "R7", "mode0 read words", {rd_got[0], rd_got[1]}, 16'h5AC3);
    chk(bad_sdot == 0, "R6", "sdo_t low during write", bad_sdot, 0);
    chk(stall_bad == 0 && stall_cycles > 0, "R8", "no edge while read stalls", stall_bad, 0);
    chk(sclk == 0 && sdo_t == 1, "R3", "clock rests low afterwards", {sclk, sdo_t}, 1);
  endtask

  task automatic test_clock();
    cfg(2'b00, 8'd3); cfg(2'b01, 8'h02);
    #1 chk(sclk == 1, "R3", "cpol1 rest level", sclk, 1);
    prep(8, 1, 0, 1, 0, 0);
    send(16'h0000);
    wait_done();
    chk(toggles == 16, "R3", "edges per word", toggles, 16);
    chk(gap_min == 4 && gap_max == 4, "R3", "half period div=3", {gap_min[7:0], gap_max[7:0]}, 16'h0404);
    chk(bad_sdot == 0, "R6", "sdo_t high without write", bad_sdot, 0);
    chk(sclk == 1, "R3", "rest high after transfer", sclk, 1);
  endtask

  task automatic test_cpha1();
    cfg(2'b00, 8'd0); cfg(2'b01, 8'h03);
    wr_arr[0] = 8'h96; s_tx[0] = 8'h69;
    prep(8, 1, 1, 0, 1, 0);
    send(16'h0300);
    wait_done();
    chk(rx_words[0] == 8'h96 && nrx == 1, "R5", "mode3 SDO word", rx_words[0], 8'h96);
    chk(rd_got[0] == 8'h69 && nrd == 1, "R5", "mode3 SDI word", rd_got[0], 8'h69);
    cfg(2'b01, 8'h01);
    wr_arr[0] = 8'hE1; s_tx[0] = 8'h1E;
    prep(8, 0, 1, 0, 1, 0);
    send(16'h0300);
    wait_done();
    chk(rx_words[0] == 8'hE1, "R5", "mode1 SDO word", rx_words[0], 8'hE1);
    chk(rd_got[0] == 8'h1E, "R5", "mode1 SDI word", rd_got[0], 8'h1E);
  endtask

  task automatic test_length();
    cfg(2'b00, 8'd1); cfg(2'b01, 8'h00); cfg(2'b10, 8'd5);
    wr_arr[0] = 8'hF3; s_tx[0] = 8'h15;
    prep(5, 0, 0, 0, 1, 0);
    send(16'h0300);
    wait_done();
    chk(toggles == 10, "R9", "edges for 5-bit word", toggles, 10);
    chk(rx_words[0] == 8'h13, "R9", "low 5 bits sent", rx_words[0], 8'h13);
    chk(rd_got[0] == 8'h15, "R9", "5-bit read right-aligned", rd_got[0], 8'h15);
    cfg(2'b10, 8'd0);
    s_tx[0] = 8'hB7;
    prep(8, 0, 0, 1, 0, 0);
    send(16'h0200);
    wait_done();
    chk(toggles == 16 && rd_got[0] == 8'hB7, "R9", "length 0 means full width", rd_got[0], 8'hB7);
    cfg(2'b10, 8'd8);
  endtask

  task automatic test_stall();
    cfg(2'b00, 8'd0); cfg(2'b01, 8'h00);
    wr_arr[0] = 8'h11; wr_arr[1] = 8'h22; wr_arr[2] = 8'h33;
    s_tx[0] = 8'h44; s_tx[1] = 8'h55; s_tx[2] = 8'h66;
    prep(8, 0, 0, 0, 3, 6);
    hold_at = 1; hold_len = 12;
    send(16'h0302);
    wait_done();
    chk(stall_bad == 0, "R8", "edges during stall", stall_bad, 0);
    chk(stall_cycles >= 12, "R8", "stall observed", stall_cycles, 12);
    chk(rx_words[1] == 8'h22 && rx_words[2] == 8'h33, "R6", "words after stall",
        {rx_words[1], rx_words[2]}, 16'h2233);
    chk(rd_got[0] == 8'h44 && rd_got[2] == 8'h66 && nrd == 3, "R7", "reads with slow sink",
        {rd_got[0], rd_got[2]}, 16'h4466);
  endtask

  task automatic test_idle();
    cfg(2'b01, 8'h08);
    #1 chk(sdo == 1, "R10", "rest level while idle", sdo, 1);
    s_tx[0] = 8'h0F; s_tx[1] = 8'hF0;
    prep(8, 0, 0, 1, 0, 0);
    tb_idle_exp = 1; tb_idle_val = 1;
    send(16'h0201);
    wait_done();
    chk(bad_idle == 0 && nrx == 2, "R10", "read-only keeps rest level", bad_idle, 0);
    chk(rd_got[1] == 8'hF0, "R7", "read-only second word", rd_got[1], 8'hF0);
    cs_act = 0;
    wr_arr[0] = 8'h00;
    prep(8, 0, 0, 0, 1, 0);
    tb_idle_exp = 1; tb_idle_val = 1;
    send(16'h0100);
    wait_done();
    chk(bad_idle == 0 && bad_sdot == 0, "R10", "cs inactive holds rest level", bad_idle, 0);
    cs_act = 1;
  endtask

  task automatic test_mode_reg();
    cfg(2'b01, 8'h04);
    #1 chk(three_wire == 1 && sclk == 0 && sdo == 0, "R10", "three_wire from bit 2", {three_wire, sclk, sdo}, 4);
    cfg(2'b01, 8'hF0);
    #1 chk(three_wire == 0 && sclk == 0 && sdo == 0, "R2", "reserved mode bits dropped", {three_wire, sclk, sdo}, 0);
    cfg(2'b01, 8'h06);
    cfg(2'b11, 8'h00);
    #1 chk(three_wire == 1 && sclk == 1, "R2", "register 11 changes nothing", {three_wire, sclk}, 3);
    cfg(2'b01, 8'h00);
  endtask

  task automatic test_side();
    prep(8, 0, 0, 1, 0, 0);
    side_ready = 0;
    @(negedge clk);
    cmd_data = 16'h1003; cmd_valid = 1;
    #1;
    chk(side_valid == 1 && side_cmd == 16'h1003, "R11", "forwarded command", side_cmd, 16'h1003);
    chk(cmd_ready == 0, "R11", "ready follows side_ready low", cmd_ready, 0);
    repeat (4) @(negedge clk);
    #1 chk(side_valid == 1 && cmd_ready == 0, "R11", "held while timing unit busy", cmd_ready, 0);
    side_ready = 1;
    #1 chk(cmd_ready == 1, "R11", "ready follows side_ready high", cmd_ready, 1);
    @(negedge clk);
    cmd_data = 16'h3105;
    #1 chk(side_valid == 1 && side_cmd == 16'h3105, "R11", "second forwarded command", side_cmd, 16'h3105);
    @(negedge clk);
    cmd_valid = 0; cmd_data = 0; side_ready = 0;
    repeat (10) @(negedge clk);
    chk(toggles == 0 && !wr_ready && !rd_valid, "R11", "no serial activity", toggles, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_mode0();
    test_clock();
    test_cpha1();
    test_length();
    test_stall();
    test_idle();
    test_mode_reg();
    test_side();
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule